// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two 16-bit timer/counters, timer 0 and timer 1, each kept as a low byte and a high byte. Each timer advances either on a one-cycle tick strobe from a prescaler outside the block or on falling edges of its own external count pin. A run bit starts and stops it. An optional gate lets the timer advance only while its gate pin is high. A shared mode register picks one of four counting modes for each timer. A hardware-set overflow flag is kept per timer. Software clears it with a control write, or the interrupt controller clears it with an acknowledge strobe.

Software reaches the block through a single write port. That port selects the mode register, the control register (run bits and flags) or any of the four count bytes. The counts, flags, run bits and mode register are presented as outputs to be read. Mode 3 changes the structure of the pair. Timer 0 becomes two independent 8-bit counters: the low byte follows timer 0's run bit and the high byte follows timer 1's run bit. Timer 1 freezes if it is itself put in mode 3.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counts, the mode register, both run bits and both overflow flags read 0.
- R2: Mode 0 is a 13-bit count. The high byte sits above the low byte's bits 4:0, and bits 7:5 of the low byte are kept unchanged. Going from 13'h1FFF to 0 sets the timer's flag.
- R3: Mode 1 is a 16-bit count. It wraps from 16'hFFFF to 0 and sets the timer's flag.
- R4: In mode 2 the low byte counts, and on passing 8'hFF it reloads from the high byte and sets the flag. The high byte does not change.
- R5: With timer 0 in mode 3, its low byte is an 8-bit counter controlled by run0 and by timer 0's gate and source; its overflow sets flag 0. Its high byte is an 8-bit counter of tick strobes controlled by run1 only; its overflow sets flag 1.
- R6: Timer 1 in mode 3 holds its count whatever its run bit, ticks or pins do.
- R7: While timer 0 is in mode 3 and timer 1 is not, timer 1 counts without regard to run1, and its overflows set no flag.
- R8: With its gate bit at 1 a timer advances only while its gate pin (after a two-flop synchroniser) is high; with the gate bit at 0 the pin is ignored.
- R9: With the count-select bit at 1, a timer advances once per falling edge of its count pin, and tick_en is ignored. The count changes on the third rising clock edge after the pin falls.
- R10: With its run bit at 0, a timer (outside split mode) keeps its count bytes.
- R11: Control writes (wr_sel 1) load run0 from bit 0, run1 from bit 1, flag 0 from bit 2 and flag 1 from bit 3. irq_ack[i] clears flag i. A hardware overflow in the same cycle wins over both the clear and the write.
- R12: A write to a count byte in the same cycle as an increment stores the written value in that byte.
- R13: wr_sel 0 loads the mode register: bits 7:4 configure timer 1 and bits 3:0 configure timer 0, each ordered gate, count select, mode[1:0]. wr_sel 2/3 write timer 0 low/high and wr_sel 4/5 write timer 1 low/high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal tick strobe from the prescaler |
| cnt_pin | input | 2 | External count pins, index = timer |
| gate_pin | input | 2 | External gate pins, index = timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| irq_ack | input | 2 | Interrupt acknowledge, clears the flag of that timer |
| t0_count | output | 16 | Timer 0 count, high byte above low byte |
| t1_count | output | 16 | Timer 1 count |
| ovf_flag | output | 2 | Overflow flags, index = timer |
| run_bit | output | 2 | Run bits, index = timer |
| mode_cfg | output | 8 | Mode register |

## Verification
The sweep runs both timers through modes 0 to 2 from start values chosen so that runs stop just short of a wrap, cross one wrap, or cross many reloads. A wrong carry point in the 13-bit mode would corrupt low-byte bits 7:5 or flag at the wrong count. A wrong reload would leave the low byte at zero instead of the high byte's value. The split-mode tests check that each half of timer 0 follows the correct run bit and that the high half drives flag 1. A design that let timer 1 set that flag, or stop on run1, would be caught. Directed cases cover the three-edge pin latency, the gate, the flag race between a hardware set and an acknowledge, and a byte write landing on an increment.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PRE_W  = 5;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [1:0] {
    TM_PRE13   = 2'd0,
    TM_WIDE16  = 2'd1,
    TM_RELOAD8 = 2'd2,
    TM_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      csel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [SEL_W-1:0] SEL_MODE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LO0  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_HI0  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LO1  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_HI1  = 3'd5;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned BW        = 8,
  parameter int unsigned PW        = 5,
  parameter bit          CAN_SPLIT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tmr_mode_e       mode,
  input  logic            inc_a,
  input  logic            inc_b,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wr_data,
  output logic [2*BW-1:0] cnt,
  output logic            ovf_a,
  output logic            ovf_b
);
  localparam int unsigned PCW = BW + PW;
  localparam int unsigned WW  = 2 * BW;
  localparam logic [PCW:0]  ONE_P = 1;
  localparam logic [WW:0]   ONE_W = 1;
  localparam logic [BW-1:0] ONE_B = 1;

  logic [BW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [PCW:0]  sum_p;
  logic [WW:0]   sum_w;

  always_comb begin
    sum_p = {1'b0, hi_q, lo_q[PW-1:0]} + ONE_P;
    sum_w = {1'b0, hi_q, lo_q} + ONE_W;
    lo_d  = lo_q;
    hi_d  = hi_q;
    ovf_a = 1'b0;
    ovf_b = 1'b0;
    case (mode)
      TM_PRE13: if (inc_a) begin
        lo_d  = {lo_q[BW-1:PW], sum_p[PW-1:0]};
        hi_d  = sum_p[PCW-1:PW];
        ovf_a = sum_p[PCW];
      end
      TM_WIDE16: if (inc_a) begin
        {hi_d, lo_d} = sum_w[WW-1:0];
        ovf_a        = sum_w[WW];
      end
      TM_RELOAD8: if (inc_a) begin
        if (&lo_q) begin
          lo_d  = hi_q;
          ovf_a = 1'b1;
        end else begin
          lo_d = lo_q + ONE_B;
        end
      end
      default: if (CAN_SPLIT) begin
        if (inc_a) begin
          lo_d  = lo_q + ONE_B;
          ovf_a = &lo_q;
        end
        if (inc_b) begin
          hi_d  = hi_q + ONE_B;
          ovf_b = &hi_q;
        end
      end
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt = {hi_q, lo_q};
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       cnt_pin,
  input  logic [1:0]       gate_pin,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]       irq_ack,
  output logic [2*BYTE_W-1:0] t0_count,
  output logic [2*BYTE_W-1:0] t1_count,
  output logic [1:0]       ovf_flag,
  output logic [1:0]       run_bit,
  output logic [BYTE_W-1:0] mode_cfg
);
  localparam int unsigned NT = 2;

  logic       rst_meta_q, rst_n_i;
  logic [7:0] mode_q, mode_d;
  logic [1:0] run_q, run_d, flag_q, flag_d;
  logic [1:0] pin_fall, gate_lvl, pin_lvl_unused, gate_fall_unused;
  logic [1:0] src, open;
  logic [1:0] hw_set;
  tmr_cfg_t   cfg [NT];
  logic       t0_split;
  logic       inc0a, inc0b, inc1a;
  logic       u0_ovf_a, u0_ovf_b, u1_ovf_a, u1_ovf_b;
  logic       wr_mode, wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  assign cfg[0] = tmr_cfg_t'(mode_q[3:0]);
  assign cfg[1] = tmr_cfg_t'(mode_q[7:4]);

  for (genvar i = 0; i < NT; i++) begin : g_pin
    tmr_sync #(.STAGES(2)) cnt_sync_i (
      .clk(clk), .rst_n(rst_n_i), .pin(cnt_pin[i]),
      .lvl(pin_lvl_unused[i]), .fall(pin_fall[i]));
    tmr_sync #(.STAGES(2)) gate_sync_i (
      .clk(clk), .rst_n(rst_n_i), .pin(gate_pin[i]),
      .lvl(gate_lvl[i]), .fall(gate_fall_unused[i]));
    assign src[i]  = cfg[i].csel ? pin_fall[i] : tick_en;
    assign open[i] = ~cfg[i].gate | gate_lvl[i];
  end

  assign t0_split = (cfg[0].mode == TM_SPLIT);
  assign inc0a    = run_q[0] & open[0] & src[0];
  assign inc0b    = t0_split & run_q[1] & tick_en;
  assign inc1a    = (t0_split | run_q[1]) & open[1] & src[1];

  tmr_unit #(.BW(BYTE_W), .PW(PRE_W), .CAN_SPLIT(1'b1)) u0_i (
    .clk(clk), .rst_n(rst_n_i), .mode(cfg[0].mode),
    .inc_a(inc0a), .inc_b(inc0b),
    .wr_lo(wr_en && wr_sel == SEL_LO0), .wr_hi(wr_en && wr_sel == SEL_HI0),
    .wr_data(wr_data), .cnt(t0_count), .ovf_a(u0_ovf_a), .ovf_b(u0_ovf_b));

  tmr_unit #(.BW(BYTE_W), .PW(PRE_W), .CAN_SPLIT(1'b0)) u1_i (
    .clk(clk), .rst_n(rst_n_i), .mode(cfg[1].mode),
    .inc_a(inc1a), .inc_b(1'b0),
    .wr_lo(wr_en && wr_sel == SEL_LO1), .wr_hi(wr_en && wr_sel == SEL_HI1),
    .wr_data(wr_data), .cnt(t1_count), .ovf_a(u1_ovf_a), .ovf_b(u1_ovf_b));

  assign hw_set[0] = u0_ovf_a;
  assign hw_set[1] = t0_split ? u0_ovf_b : (u1_ovf_a | u1_ovf_b);
  assign wr_mode   = wr_en && (wr_sel == SEL_MODE);
  assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);

  always_comb begin
    mode_d = wr_mode ? wr_data : mode_q;
    run_d  = wr_ctrl ? wr_data[1:0] : run_q;
    for (int i = 0; i < NT; i++) begin
      flag_d[i] = flag_q[i] & ~irq_ack[i];
      if (wr_ctrl)   flag_d[i] = wr_data[2+i];
      if (hw_set[i]) flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign ovf_flag = flag_q;
  assign run_bit  = run_q;
  assign mode_cfg = mode_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] t0_count,
  input logic [15:0] t1_count,
  input logic [1:0]  ovf_flag,
  input logic [1:0]  run_bit,
  input logic [7:0]  mode_cfg
);
  AST_T1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cfg[5:4] == 2'b11 && !wr_en) |=> $stable(t1_count)); // R6

  AST_HALT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_bit[0] && mode_cfg[1:0] != 2'b11 && !wr_en) |=> $stable(t0_count)); // R10

  AST_RELOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cfg[1:0] == 2'b10 && !wr_en) |=>
      (t0_count[15:8] == $past(t0_count[15:8]) &&
       (t0_count[7:0] == $past(t0_count[7:0]) ||
        t0_count[7:0] == $past(t0_count[7:0]) + 8'd1 ||
        t0_count[7:0] == $past(t0_count[15:8])))); // R4

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag[0]) |-> ($past(wr_en) || $past(run_bit[0]))); // R11

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_cfg)); // R13
endmodule

bind tmr_pair tmr_pair_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .t0_count(t0_count), .t1_count(t1_count),
  .ovf_flag(ovf_flag), .run_bit(run_bit), .mode_cfg(mode_cfg));

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  cnt_pin = 2'b00;
  logic [1:0]  gate_pin = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [1:0]  irq_ack = 2'b00;
  logic [15:0] t0_count, t1_count;
  logic [1:0]  ovf_flag, run_bit;
  logic [7:0]  mode_cfg;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  tmr_pair dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_ack(irq_ack), .t0_count(t0_count), .t1_count(t1_count),
    .ovf_flag(ovf_flag), .run_bit(run_bit), .mode_cfg(mode_cfg));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int model(input int m, input int start, input int n, output bit ov);
    int lo = start & 255;
    int hi = (start >> 8) & 255;
    int s;
    int r;
    if (m == 0) begin
      s = ((hi << 5) | (lo & 31)) + n;
      ov = (s >= 8192);
      s = s % 8192;
      return ((s >> 5) << 8) | (lo & 224) | (s & 31);
    end else if (m == 1) begin
      s = start + n;
      ov = (s >= 65536);
      return s % 65536;
    end else begin
      if (n <= 255 - lo) begin
        ov = 1'b0;
        return (hi << 8) | (lo + n);
      end
      r = n - (256 - lo);
      ov = 1'b1;
      return (hi << 8) | (hi + (r % (256 - hi)));
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int starts[4] = '{32'hFFF0, 32'h1FE0, 32'h0000, 32'h80FA};
    int lens[4]   = '{1, 7, 40, 300};
    int exp;
    bit ov;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    check("R1 t0", t0_count, 0);
    check("R1 t1", t1_count, 0);
    check("R1 flags", ovf_flag, 0);
    check("R1 run", run_bit, 0);
    check("R1 mode", mode_cfg, 0);

    // R2 R3 R4 sweep: both timers, modes 0..2
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 3; m++)
        for (int si = 0; si < 4; si++)
          for (int li = 0; li < 4; li++) begin
            wr(3'd1, 8'h00);
            wr(3'd0, (t == 0) ? 8'(m) : 8'(m << 4));
            wr((t == 0) ? 3'd2 : 3'd4, 8'(starts[si] & 255));
            wr((t == 0) ? 3'd3 : 3'd5, 8'(starts[si] >> 8));
            wr(3'd1, (t == 0) ? 8'h01 : 8'h02);
            ticks(lens[li]);
            exp = model(m, starts[si], lens[li], ov);
            check(m == 0 ? "R2 count" : (m == 1 ? "R3 count" : "R4 count"),
                  (t == 0) ? t0_count : t1_count, exp);
            check(m == 0 ? "R2 flag" : (m == 1 ? "R3 flag" : "R4 flag"),
                  ovf_flag[t], int'(ov));
          end

    // R13 R8 layout and gate: timer1 gated mode0, timer0 mode1
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h81);
    for (int s = 2; s < 6; s++) wr(3'(s), 8'h00);
    wr(3'd1, 8'h03);
    ticks(5);
    check("R13 t0 mode1 ungated", t0_count, 5);
    check("R8 gate low holds", t1_count, 0);
    gate_pin[1] = 1'b1;
    idle(4);
    ticks(5);
    check("R8 gate high counts", t1_count, 5);
    check("R13 t0 second run", t0_count, 10);
    gate_pin[1] = 1'b0;

    // R9 external count source on timer0
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cnt_pin[0] = 1'b1;
    wr(3'd1, 8'h01);
    idle(4);
    ticks(10);
    check("R9 tick ignored", t0_count, 0);
    @(negedge clk); cnt_pin[0] = 1'b0;
    idle(2);
    check("R9 not yet at 2 edges", t0_count, 0);
    idle(1);
    check("R9 counted at 3rd edge", t0_count, 1);
    for (int k = 0; k < 5; k++) begin
      idle(3); cnt_pin[0] = 1'b1;
      idle(3); cnt_pin[0] = 1'b0;
    end
    idle(4);
    check("R9 edge count", t0_count, 6);

    // R10 run cleared holds
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wr(3'd1, 8'h00);
    ticks(20);
    check("R10 halted", t0_count, 16'h1234);

    // R11 flag clear by ack; hw set beats ack
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h05);
    check("R11 sw set flag", ovf_flag[0], 1);
    @(negedge clk); tick_en = 1'b1; irq_ack[0] = 1'b1;
    @(negedge clk); tick_en = 1'b0; irq_ack[0] = 1'b0;
    check("R11 hw set beats ack", ovf_flag[0], 1);
    check("R11 wrapped", t0_count, 0);
    @(negedge clk); irq_ack[0] = 1'b1;
    @(negedge clk); irq_ack[0] = 1'b0;
    check("R11 ack clears", ovf_flag[0], 0);

    // R12 write beats increment
    wr(3'd2, 8'h00); wr(3'd3, 8'h12);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'h33;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R12 write wins", t0_count, 16'h1233);

    // R5 R6 split timer0, timer1 frozen in mode 3
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h33);
    wr(3'd2, 8'h10); wr(3'd3, 8'hFE);
    wr(3'd4, 8'h55); wr(3'd5, 8'hAA);
    wr(3'd1, 8'h01);
    ticks(5);
    check("R5 low half on run0", t0_count, 16'hFE15);
    wr(3'd1, 8'h02);
    ticks(3);
    check("R5 high half on run1", t0_count, 16'h0115);
    check("R5 high overflow sets flag1", ovf_flag[1], 1);
    check("R5 flag0 untouched", ovf_flag[0], 0);
    check("R6 timer1 frozen", t1_count, 16'hAA55);

    // R7 timer1 runs free while timer0 split, no flag
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h13);
    wr(3'd4, 8'hF0); wr(3'd5, 8'hFF);
    ticks(32);
    check("R7 timer1 counts without run1", t1_count, 16'h0010);
    check("R7 no flag from timer1", ovf_flag[1], 0);
    check("R7 timer0 halves idle", t0_count, 16'h0115);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule